// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM. The address and the command are captured on one rising clock edge, and the matching data transfer takes place in the clock cycle that follows. Because every command has a data phase of exactly one cycle, reads and writes can alternate on the shared data bus with no idle cycle between them. Read data comes straight from the array during its data cycle, with no output register. The bidirectional bus is modelled as three ports: `dq_in`, `dq_out` and a drive enable `dq_oe`.

The core is a small finite-state machine that tracks what the current data cycle does. It has three states:
- `PH_IDLE`: no transfer.
- `PH_READ`: the array drives the bus.
- `PH_WRITE`: data is taken from `dq_in` at the next enabled edge.

The state is chosen at every enabled edge. The transitions are:
- *load-read*: a selected load with `we_n` high goes to `PH_READ`.
- *load-write*: a selected load with `we_n` low goes to `PH_WRITE`.
- *load-deselect*: a load with any enable inactive goes to `PH_IDLE`.
- *advance-active*: a continuation while a burst is open repeats the latched direction.
- *advance-dead*: a continuation with no open burst goes to `PH_IDLE`.
- *stall*: with `cke_n` high, the machine stays in its state.

A burst takes one loaded address and produces four data cycles. The low address bits are stepped in linear or interleaved order.

Top module: `ft_sync_sram`

## Requirements
- R1: A selected load (`adv_ld`=0, `sel_a_n`=0, `sel_b`=1, `sel_c_n`=0, `cke_n`=0) with `we_n`=1 drives the word at `addr` on `dq_out` with `dq_oe`=1 during the next clock cycle. The data is read from the array in that cycle, not from a register.
- R2: Reads and writes may be issued on consecutive edges in any mix. A read that directly follows a write to the same word returns the newly written data.
- R3: While `cke_n`=1, every synchronous input is ignored. The state, the data-phase address and the burst position are held, and no array write occurs. A pending write takes `dq_in` at the next edge where `cke_n`=0.
- R4: A load with any of the three enables inactive starts no operation, and `dq_oe` is 0 in the next cycle. A write whose data phase is already open still completes with the `dq_in` presented at that edge.
- R5: During the data cycle of a write, `dq_oe` is 0.
- R6: A continuation (`adv_ld`=1) steps a 2-bit burst count and reuses the direction latched at the last load. Address bits above bit 1 never change. A continuation after a deselecting load, or after reset, performs no access.
- R7: With `seq_lin`=1 captured at the load, the data-phase address low bits are (loaded low bits + count) mod 4.
- R8: With `seq_lin`=0 captured at the load, the data-phase address low bits are the loaded low bits XOR count.
- R9: A word is made of 4 lanes of 9 bits, with lane i at bits [9i+8:9i]. Lane i is written only when `bw_n[i]`=0. `bw_n` is sampled with each command, including each continuation.
- R10: `oe_n`=1 forces `dq_oe` to 0 at once, with no clock edge needed.
- R11: After reset, the state is `PH_IDLE`, no burst is open, `dq_oe`=0 and every word of the array reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge samples the inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Clock enable, active low; high stalls the block |
| adv_ld | input | 1 | 0 loads a new address, 1 continues the burst |
| we_n | input | 1 | 1 read, 0 write; sampled at a load |
| sel_a_n | input | 1 | Chip enable, active low |
| sel_b | input | 1 | Chip enable, active high |
| sel_c_n | input | 1 | Chip enable, active low |
| seq_lin | input | 1 | Burst order: 1 linear, 0 interleaved; sampled at a load |
| bw_n | input | 4 | Lane write enables, active low |
| addr | input | 6 | Word address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | 36 | Write data for the current data cycle |
| dq_out | output | 36 | Read data from the array |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The event that stresses the block most is a write commit that lands in the same cycle as a new read command for the same word. The array must then take the write and serve the read in the cycle right after. The bench provokes this with write/read pairs on one address, and with a deselecting load issued while a write data phase is open. The scoreboard model applies its own commit before it forms the read expectation, so any stale word or lost write shows up as a data mismatch. A stall placed in the middle of a write burst also checks that a commit and a `cke_n` stall on the same edge never both take effect.

// File: rtl/ftsram_pkg.sv
package ftsram_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;

    // Low two address bits of a burst beat.
    function automatic logic [1:0] beat_low(input logic [1:0] start,
                                             input logic [1:0] step,
                                             input logic       linear);
        return linear ? 2'(start + step) : (start ^ step);
    endfunction

endpackage

// File: rtl/ftsram_burst.sv
module ftsram_burst #(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [1:0]        step,
    input  logic              linear,
    output logic [ADDR_W-1:0] beat_addr
);
    import ftsram_pkg::*;

    always_comb begin
        beat_addr = {base[ADDR_W-1:2], beat_low(base[1:0], step, linear)};
    end

endmodule

// File: rtl/ftsram_array.sv
module ftsram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_go,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [LANES-1:0]         lane_n,
    input  logic [LANES*LANE_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [LANES*LANE_W-1:0]  rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] cells [LANES][DEPTH];

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int w = 0; w < DEPTH; w++) begin
                        cells[g][w] <= '0;
                    end
                end else if (wr_go && !lane_n[g]) begin
                    cells[g][wr_addr] <= wr_data[g*LANE_W +: LANE_W];
                end
            end

            // Flow-through read: no output register.
            always_comb begin
                rd_data[g*LANE_W +: LANE_W] = cells[g][rd_addr];
            end
        end
    endgenerate

endmodule

// File: rtl/ftsram_ctrl.sv
module ftsram_ctrl
    import ftsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  logic              adv_ld,
    input  logic              we_n,
    input  logic              chip_on,
    input  logic              seq_lin,
    input  logic [LANES-1:0]  bw_n,
    input  logic [ADDR_W-1:0] addr,
    output phase_e            phase,
    output logic [ADDR_W-1:0] ph_addr,
    output logic [LANES-1:0]  ph_lane_n,
    output logic              commit,
    output logic              rd_phase
);
    phase_e            nx_phase;
    logic [ADDR_W-1:0] nx_addr;
    logic [LANES-1:0]  nx_lane_n;
    logic [ADDR_W-1:0] b_base, nb_base;
    logic [1:0]        b_step, nb_step;
    logic              b_lin, nb_lin;
    logic              b_wr, nb_wr;
    logic              b_open, nb_open;
    logic [ADDR_W-1:0] adv_addr;
    logic [1:0]        step_inc;

    assign step_inc = b_step + 2'd1;

    ftsram_burst #(.ADDR_W(ADDR_W)) u_burst (
        .base      (b_base),
        .step      (step_inc),
        .linear    (b_lin),
        .beat_addr (adv_addr)
    );

    // Next-state decode
    always_comb begin
        nx_phase  = phase;
        nx_addr   = ph_addr;
        nx_lane_n = ph_lane_n;
        nb_base   = b_base;
        nb_step   = b_step;
        nb_lin    = b_lin;
        nb_wr     = b_wr;
        nb_open   = b_open;
        if (!cke_n) begin
            if (!adv_ld) begin
                if (chip_on) begin
                    nx_phase  = we_n ? PH_READ : PH_WRITE;
                    nx_addr   = addr;
                    nx_lane_n = bw_n;
                    nb_base   = addr;
                    nb_step   = 2'd0;
                    nb_lin    = seq_lin;
                    nb_wr     = !we_n;
                    nb_open   = 1'b1;
                end else begin
                    nx_phase  = PH_IDLE;
                    nb_open   = 1'b0;
                end
            end else begin
                nb_step = step_inc;
                if (b_open) begin
                    nx_phase  = b_wr ? PH_WRITE : PH_READ;
                    nx_addr   = adv_addr;
                    nx_lane_n = bw_n;
                end else begin
                    nx_phase  = PH_IDLE;
                end
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            ph_addr   <= '0;
            ph_lane_n <= '1;
            b_base    <= '0;
            b_step    <= 2'd0;
            b_lin     <= 1'b0;
            b_wr      <= 1'b0;
            b_open    <= 1'b0;
        end else begin
            phase     <= nx_phase;
            ph_addr   <= nx_addr;
            ph_lane_n <= nx_lane_n;
            b_base    <= nb_base;
            b_step    <= nb_step;
            b_lin     <= nb_lin;
            b_wr      <= nb_wr;
            b_open    <= nb_open;
        end
    end

    // Outputs of the current data cycle
    always_comb begin
        commit   = 1'b0;
        rd_phase = 1'b0;
        unique case (phase)
            PH_IDLE:  ;
            PH_READ:  rd_phase = 1'b1;
            PH_WRITE: commit   = !cke_n;
            default:  ;
        endcase
    end

endmodule

// File: rtl/ft_sync_sram.sv
module ft_sync_sram #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cke_n,
    input  logic                    adv_ld,
    input  logic                    we_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    seq_lin,
    input  logic [LANES-1:0]        bw_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_oe
);
    import ftsram_pkg::*;

    phase_e            phase_st;
    logic [ADDR_W-1:0] phase_addr;
    logic [LANES-1:0]  phase_lane_n;
    logic              commit;
    logic              rd_phase;
    logic              chip_on;

    assign chip_on = !sel_a_n && sel_b && !sel_c_n;

    ftsram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke_n     (cke_n),
        .adv_ld    (adv_ld),
        .we_n      (we_n),
        .chip_on   (chip_on),
        .seq_lin   (seq_lin),
        .bw_n      (bw_n),
        .addr      (addr),
        .phase     (phase_st),
        .ph_addr   (phase_addr),
        .ph_lane_n (phase_lane_n),
        .commit    (commit),
        .rd_phase  (rd_phase)
    );

    ftsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_go   (commit),
        .wr_addr (phase_addr),
        .lane_n  (phase_lane_n),
        .wr_data (dq_in),
        .rd_addr (phase_addr),
        .rd_data (dq_out)
    );

    // Asynchronous output enable gates the drive.
    assign dq_oe = rd_phase && !oe_n;

endmodule

// File: rtl/ftsram_chk.sv
module ftsram_chk
    import ftsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke_n,
    input logic              adv_ld,
    input logic              we_n,
    input logic              sel_a_n,
    input logic              sel_b,
    input logic              sel_c_n,
    input logic              oe_n,
    input logic              dq_oe,
    input phase_e            phase_st,
    input logic [ADDR_W-1:0] phase_addr
);
    logic sel_ok;
    assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

    assert_read_flow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_ld && sel_ok && we_n) |=> (dq_oe || oe_n));

    assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(phase_st) && $stable(phase_addr)));

    assert_desel_float_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_ld && !sel_ok) |=> !dq_oe);

    assert_write_float_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_ld && sel_ok && !we_n) |=> !dq_oe);

    assert_burst_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv_ld && phase_st != PH_IDLE)
        |=> (phase_addr[ADDR_W-1:2] == $past(phase_addr[ADDR_W-1:2])));

    assert_dead_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv_ld && phase_st == PH_IDLE) |=> (phase_st == PH_IDLE));

    assert_oe_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);

endmodule

bind ft_sync_sram ftsram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke_n      (cke_n),
    .adv_ld     (adv_ld),
    .we_n       (we_n),
    .sel_a_n    (sel_a_n),
    .sel_b      (sel_b),
    .sel_c_n    (sel_c_n),
    .oe_n       (oe_n),
    .dq_oe      (dq_oe),
    .phase_st   (phase_st),
    .phase_addr (phase_addr)
);

// File: tb/ft_sync_sram_bench.sv
`timescale 1ns/1ps
module ft_sync_sram_bench;
    localparam int AW = 6;
    localparam int DW = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke_n = 1'b0, adv_ld = 1'b0, we_n = 1'b1;
    logic          sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
    logic          seq_lin = 1'b0, oe_n = 1'b0;
    logic [3:0]    bw_n = 4'hF;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    always #2 clk = ~clk;

    ft_sync_sram u_ft_sync_sram (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .adv_ld(adv_ld), .we_n(we_n),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .seq_lin(seq_lin),
        .bw_n(bw_n), .addr(addr), .oe_n(oe_n), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    typedef struct {
        int            due;
        bit            drv;
        logic [DW-1:0] val;
        string         req;
    } exp_t;
    exp_t q[$];

    // Reference model state
    logic [DW-1:0] ref_mem [1 << AW];
    bit            p_v, p_wr;
    logic [AW-1:0] p_addr;
    logic [3:0]    p_bw;
    bit            m_open, m_wr, m_lin;
    logic [AW-1:0] m_base;
    logic [1:0]    m_step;
    int            desel_k = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic report(input bit ok, input string req, input logic [DW-1:0] act,
                          input logic [DW-1:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // Monitor: pops scoreboard entries as data cycles occur
    always @(posedge clk) begin
        #1;
        if (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            if (e.drv) begin
                report(dq_oe === 1'b1, {e.req, " drive"}, {35'd0, dq_oe}, 36'd1);
                report(dq_out === e.val, {e.req, " data"}, dq_out, e.val);
            end else begin
                report(dq_oe === 1'b0, {e.req, " float"}, {35'd0, dq_oe}, 36'd0);
            end
        end
    end

    // Driver: one command per clock, with the data for the open data phase
    task automatic tick(input bit en, input bit adv, input bit rd, input bit cs,
                        input int a, input logic [3:0] bw, input bit lin,
                        input logic [DW-1:0] din, input bit oe_off, input string req);
        logic [1:0] lo;
        @(negedge clk);
        cke_n  = !en;
        adv_ld = adv;
        we_n   = rd;
        addr   = AW'(a);
        bw_n   = bw;
        seq_lin = lin;
        dq_in  = din;
        oe_n   = oe_off;
        if (cs) begin
            sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
        end else begin
            sel_a_n = (desel_k == 0); sel_b = (desel_k != 1); sel_c_n = (desel_k == 2);
            desel_k = (desel_k + 1) % 3;
        end
        if (en) begin
            if (p_v && p_wr)
                for (int l = 0; l < 4; l++)
                    if (!p_bw[l]) ref_mem[p_addr][l*9 +: 9] = din[l*9 +: 9];
            if (!adv) begin
                if (cs) begin
                    m_open = 1; m_base = AW'(a); m_step = 0; m_lin = lin; m_wr = !rd;
                    p_v = 1; p_wr = !rd; p_addr = AW'(a); p_bw = bw;
                end else begin
                    m_open = 0; p_v = 0;
                end
            end else begin
                m_step = m_step + 2'd1;
                if (m_open) begin
                    lo = m_lin ? 2'(m_base[1:0] + m_step) : (m_base[1:0] ^ m_step);
                    p_v = 1; p_wr = m_wr; p_addr = {m_base[AW-1:2], lo}; p_bw = bw;
                end else begin
                    p_v = 0;
                end
            end
        end
        if (p_v && !p_wr && !oe_off)
            q.push_back('{cyc + 1, 1'b1, ref_mem[p_addr], req});
        else
            q.push_back('{cyc + 1, 1'b0, '0, req});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
        p_v = 0; p_wr = 0; p_addr = '0; p_bw = 4'hF;
        m_open = 0; m_wr = 0; m_lin = 0; m_base = '0; m_step = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        report(dq_oe === 1'b0, "R11 reset drive", {35'd0, dq_oe}, 36'd0);

        // R11: unwritten word reads zero; R6: advance after reset is dead
        tick(1, 1, 1, 1, 0, 4'h0, 0, '0, 0, "R6 advance after reset");
        tick(1, 0, 1, 1, 9, 4'h0, 0, '0, 0, "R11 cleared word");
        tick(1, 0, 1, 0, 0, 4'h0, 0, '0, 0, "R4 idle");

        // R1/R2/R5: alternating writes and reads
        tick(1, 0, 0, 1, 3, 4'h0, 0, '0, 0, "R5 write cycle");
        tick(1, 0, 1, 1, 3, 4'h0, 0, 36'h1_2345_6789, 0, "R2 read after write");
        tick(1, 0, 0, 1, 4, 4'h0, 0, '0, 0, "R5 write after read");
        tick(1, 0, 1, 1, 4, 4'h0, 0, 36'hA_BCDE_F012, 0, "R2 read after write 2");
        tick(1, 0, 1, 1, 3, 4'h0, 0, '0, 0, "R1 read");
        tick(1, 0, 0, 1, 3, 4'h0, 0, '0, 0, "R5 write after read 2");
        tick(1, 0, 1, 1, 3, 4'h0, 0, 36'h5_5AA5_0FF0, 0, "R2 overwrite read");

        // R7: linear write burst from 21, R8: interleaved read burst
        tick(1, 0, 0, 1, 21, 4'h0, 1, '0, 0, "R7 linear write load");
        tick(1, 1, 0, 1, 0, 4'h0, 0, 36'h0_0000_0E00, 0, "R7 beat1");
        tick(1, 1, 0, 1, 0, 4'h0, 0, 36'h0_0000_0E01, 0, "R7 beat2");
        tick(1, 1, 0, 1, 0, 4'h0, 0, 36'h0_0000_0E02, 0, "R7 beat3");
        tick(1, 0, 1, 1, 21, 4'h0, 0, 36'h0_0000_0E03, 0, "R8 interleaved read load");
        tick(1, 1, 1, 1, 0, 4'h0, 1, '0, 0, "R8 beat1");
        tick(1, 1, 1, 1, 0, 4'h0, 1, '0, 0, "R8 beat2");
        tick(1, 1, 1, 1, 0, 4'h0, 1, '0, 0, "R8 beat3");
        tick(1, 0, 1, 1, 22, 4'h0, 1, '0, 0, "R7 linear read load");
        tick(1, 1, 1, 1, 0, 4'h0, 0, '0, 0, "R7 read beat1");
        tick(1, 1, 1, 1, 0, 4'h0, 0, '0, 0, "R7 read beat2");

        // R3: stall inside a read burst and inside a write burst
        tick(1, 0, 1, 1, 20, 4'h0, 1, '0, 0, "R3 read burst load");
        tick(1, 1, 1, 1, 0, 4'h0, 1, '0, 0, "R3 read beat1");
        tick(0, 0, 0, 1, 7, 4'h0, 0, 36'hF_FFFF_FFFF, 0, "R3 stall hold read");
        tick(0, 0, 1, 0, 9, 4'h0, 0, '0, 0, "R3 stall hold read 2");
        tick(1, 1, 1, 1, 0, 4'h0, 1, '0, 0, "R3 read beat2");
        tick(1, 0, 0, 1, 40, 4'h0, 1, '0, 0, "R3 write burst load");
        tick(1, 1, 0, 1, 0, 4'h0, 0, 36'h0_0000_0F00, 0, "R3 write beat1");
        tick(0, 0, 1, 1, 7, 4'h0, 0, 36'hB_AD00_0BAD, 0, "R3 stall write");
        tick(1, 1, 0, 1, 0, 4'h0, 0, 36'h0_0000_0F01, 0, "R3 write beat2");
        tick(1, 1, 0, 1, 0, 4'h0, 0, 36'h0_0000_0F02, 0, "R3 write beat3");
        tick(1, 0, 1, 1, 40, 4'h0, 1, 36'h0_0000_0F03, 0, "R3 check load");
        tick(1, 1, 1, 1, 0, 4'h0, 0, '0, 0, "R3 check beat1");
        tick(1, 1, 1, 1, 0, 4'h0, 0, '0, 0, "R3 check beat2");
        tick(1, 1, 1, 1, 0, 4'h0, 0, '0, 0, "R3 check beat3");
        tick(1, 0, 1, 1, 7, 4'h0, 0, '0, 0, "R3 ignored write addr");

        // R4/R6: deselect completes open write; dead continuation
        tick(1, 0, 0, 1, 50, 4'h0, 0, '0, 0, "R4 write before deselect");
        tick(1, 0, 0, 0, 51, 4'h0, 0, 36'h3_C3C3_C3C3, 0, "R4 deselect");
        tick(1, 1, 0, 1, 0, 4'h0, 0, '0, 0, "R6 dead continuation");
        tick(1, 0, 1, 0, 50, 4'h0, 0, '0, 0, "R4 deselect 2");
        tick(1, 0, 1, 0, 50, 4'h0, 0, '0, 0, "R4 deselect 3");
        tick(1, 0, 1, 1, 50, 4'h0, 0, '0, 0, "R4 completed write");
        tick(1, 0, 1, 1, 51, 4'h0, 0, '0, 0, "R4 no write at deselect");

        // R9: partial lane writes, on a load and on continuations
        tick(1, 0, 0, 1, 50, 4'b1010, 0, '0, 0, "R9 lane write load");
        tick(1, 0, 0, 1, 60, 4'h0, 1, 36'h1_FF7F_DFF7, 0, "R9 burst lane load");
        tick(1, 1, 0, 1, 0, 4'b0111, 1, 36'h2_2222_2222, 0, "R9 beat1");
        tick(1, 1, 0, 1, 0, 4'b1110, 1, 36'h3_3333_3333, 0, "R9 beat2");
        tick(1, 0, 1, 1, 50, 4'h0, 0, 36'h4_4444_4444, 0, "R9 lanes 0 and 2");
        tick(1, 0, 1, 1, 60, 4'h0, 1, '0, 0, "R9 full word");
        tick(1, 1, 1, 1, 0, 4'h0, 1, '0, 0, "R9 lane 3 only");
        tick(1, 1, 1, 1, 0, 4'h0, 1, '0, 0, "R9 lane 0 only");

        // R10: output enable
        tick(1, 0, 1, 1, 3, 4'h0, 0, '0, 1, "R10 oe high");
        tick(1, 0, 1, 1, 3, 4'h0, 0, '0, 0, "R10 oe low");
        @(posedge clk);
        #1.5;
        oe_n = 1'b1;
        #0.3;
        report(dq_oe === 1'b0, "R10 async release", {35'd0, dq_oe}, 36'd0);
        tick(1, 0, 1, 0, 0, 4'h0, 0, '0, 0, "R4 final idle");
        repeat (3) @(negedge clk);
        report(q.size() == 0, "R1 scoreboard drained", 36'(q.size()), 36'd0);
        finish_run();
    end

endmodule